// File: doc/BRIEF.md
# Interrupt Epilogue Restore Sequencer

This block performs the closing steps of an interrupt service routine in hardware. On a start pulse it captures the current stack pointer, treats the stack pointer plus 96 as the top of a saved frame, and reads nineteen 32-bit words back from that frame one at a time through a simple request/response memory port. The words are held in an internal frame buffer. Only after the last word has arrived does it touch architectural state. It then writes seventeen general registers one per cycle and writes the stack pointer (x2) last with the frame top. In a final cycle it writes the cause CSR, updates the status fields of the selected return path and presents the new program counter together with a done pulse.

The cause value written back is a blend. The two live bits that track a pending non-maskable interrupt (bit 24) and an exception in progress (bit 25) are taken from the CSR's current value in the final cycle. All other bits come from the saved word. The path is chosen by the NMI-enable input sampled at start. The machine-return path updates the previous-enable, previous-disable-trap and previous-level fields and jumps to the trap PC. The NMI-return path updates the interrupt enable and the NMI previous level and jumps to the NMI PC. Each path clears its own set of fields in the written cause value.

Top module: `irq_epilogue_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, mem_req_o, rf_we_o, cause_we_o, mret_we_o and nret_we_o are all 0.
- R2: A start_i pulse seen while idle makes busy_o 1 from the next cycle through the done cycle. A start_i seen while busy_o is 1 is ignored, so the frame top and the read sequence stay unchanged.
- R3: With top = sp_i + 96 captured at start, exactly 19 reads are made, one outstanding at a time. mem_addr_o is held until mem_rvalid_i. The addresses run top-4, top-8, top-12, top-16, then top-24 down to top-80 in steps of 4. top-20 is never read.
- R4: Frame offset to register: -8 goes to x8, -16 to x1, -24 to x5, -28 to x6, -32 to x7, -36 through -64 to x10 through x17, -68 through -76 to x28 through x30, and -80 to x31.
- R5: No register-file or cause write occurs while reads are pending. After the last response there are exactly 18 register writes on consecutive cycles.
- R6: The last register write targets x2 with the value sp_i + 96 captured at start.
- R7: The written cause value takes bits 25:24 from cause_live_i in the done cycle and all other bits from the saved word at top-12, before clearing.
- R8: Machine-return path (NMI-enable 1 at start): the cause write clears bits 26, 27, 29 and 19:12. mret_we_o is 1, with previous-enable = saved bit 27, previous-disable-trap = saved bit 29 and previous level = saved bits 19:16. pc_o = trap_epc_i.
- R9: NMI-return path (NMI-enable 0 at start): the cause write clears bits 26, 28, 30, 15:12 and 23:20. nret_we_o is 1, with enable = saved bit 28 and previous level = saved bits 23:20. pc_o = nmi_epc_i.
- R10: The path depends only on nmi_en_i at the start cycle. Later changes to nmi_en_i have no effect.
- R11: done_o is a one-cycle pulse in which cause_we_o is 1. saved_ret_o equals the word read from top-4. busy_o is 0 in the following cycle.
- R12: A reset during the read phase returns the block to idle with no register-file or CSR write having occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a restore sequence |
| sp_i | input | XLEN | Current stack pointer, sampled at start |
| nmi_en_i | input | 1 | NMI-enable status bit, sampled at start |
| cause_live_i | input | XLEN | Current value of the cause CSR |
| trap_epc_i | input | XLEN | Machine trap return PC CSR value |
| nmi_epc_i | input | XLEN | NMI return PC CSR value |
| mem_req_o | output | 1 | Read request, held until response |
| mem_addr_o | output | XLEN | Read byte address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | XLEN | Read response data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | RA | Register-file write index |
| rf_wdata_o | output | XLEN | Register-file write data |
| cause_we_o | output | 1 | Cause CSR write enable |
| cause_wdata_o | output | XLEN | Cause CSR write data |
| mret_we_o | output | 1 | Machine-return status field write |
| mret_pie_o | output | 1 | Previous interrupt enable value |
| mret_pdt_o | output | 1 | Previous disable-trap value |
| mret_plvl_o | output | 4 | Previous interrupt level value |
| nret_we_o | output | 1 | NMI-return status field write |
| nret_ie_o | output | 1 | Machine interrupt enable value |
| nret_plvl_o | output | 4 | NMI previous level value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| pc_o | output | XLEN | New program counter, valid with done_o |
| saved_ret_o | output | XLEN | Saved return PC word, valid with done_o |

## Verification
The cause merge and the status update land in the same final cycle, and the live pending and exception bits can change in that very cycle. The bench holds cause_live_i at the complement of its target value for the whole sequence. It switches to the target only at the falling edge of the x2 write cycle, so the done cycle is the first to see it. The written cause value is then compared bit for bit with a value computed from the saved word and the target, and a stale live value would show up in bits 25:24. In the same cycle the bench also checks the path's status fields and the PC, after flipping nmi_en_i once the start has been taken.

// File: rtl/irq_epi_pkg.sv
package irq_epi_pkg;

  localparam int unsigned EPI_SLOTS = 19;
  localparam int unsigned EPI_GPRS  = 17;

  localparam int unsigned SLOT_RET   = 0;
  localparam int unsigned SLOT_CAUSE = 2;

  localparam int unsigned PEND_BIT   = 24;
  localparam int unsigned EXC_BIT    = 25;

  typedef enum logic [1:0] {
    EPI_IDLE,
    EPI_POP,
    EPI_WB,
    EPI_FIN
  } epi_state_e;

  // Byte distance below the frame top for each read slot; slot 4 skips -20.
  function automatic logic [7:0] slot_offset(input logic [4:0] s);
    logic [7:0] s8;
    s8 = {3'b000, s};
    if (s < 5'd4) return 8'((s8 + 8'd1) << 2);
    return 8'((s8 + 8'd2) << 2);
  endfunction

  // Destination register of each slot (0 for non-register slots).
  function automatic logic [4:0] slot_gpr(input logic [4:0] s);
    logic [4:0] r;
    case (s)
      5'd1:                        r = 5'd8;
      5'd3:                        r = 5'd1;
      5'd4:                        r = 5'd5;
      5'd5:                        r = 5'd6;
      5'd6:                        r = 5'd7;
      5'd7, 5'd8, 5'd9, 5'd10,
      5'd11, 5'd12, 5'd13, 5'd14:  r = s + 5'd3;
      5'd15, 5'd16, 5'd17:         r = s + 5'd13;
      5'd18:                       r = 5'd31;
      default:                     r = 5'd0;
    endcase
    return r;
  endfunction

  // Write-back step to slot: step 0 is slot 1, later steps skip the cause slot.
  function automatic logic [4:0] wb_slot(input logic [4:0] i);
    if (i == 5'd0) return 5'd1;
    return i + 5'd2;
  endfunction

endpackage

// File: rtl/epi_rst_sync.sv
module epi_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/epi_frame_buf.sv
module epi_frame_buf #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 19,
  parameter int unsigned IW = 5,
  parameter int unsigned RET_IDX   = 0,
  parameter int unsigned CAUSE_IDX = 2
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  output logic [W-1:0]  ret_word_o,
  output logic [W-1:0]  cause_word_o
);

  logic [W-1:0] slot_q [N];
  logic [N-1:0] slot_en;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign slot_en[g] = wr_en_i && (wr_idx_i == IW'(g));
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < N; k++) begin
      if (slot_en[k]) begin
        slot_q[k] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_idx_i == IW'(k)) rd_data_o = slot_q[k];
    end
  end

  assign ret_word_o   = slot_q[RET_IDX];
  assign cause_word_o = slot_q[CAUSE_IDX];

endmodule

// File: rtl/epi_csr_merge.sv
module epi_csr_merge
  import irq_epi_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] saved_i,
  input  logic [W-1:0] live_i,
  input  logic         mret_path_i,
  output logic [W-1:0] cause_o,
  output logic         pie_o,
  output logic         pdt_o,
  output logic [3:0]   plvl_o,
  output logic         ie_o,
  output logic [3:0]   nplvl_o
);

  localparam logic [W-1:0] LIVE_MASK =
    W'((64'd1 << PEND_BIT) | (64'd1 << EXC_BIT));
  localparam logic [W-1:0] CLR_MRET =
    W'((64'd1 << 26) | (64'd1 << 27) | (64'd1 << 29) | (64'hFF << 12));
  localparam logic [W-1:0] CLR_NRET =
    W'((64'd1 << 26) | (64'd1 << 28) | (64'd1 << 30) |
       (64'hF << 12) | (64'hF << 20));

  logic [W-1:0] merged;

  always_comb begin
    merged  = (saved_i & ~LIVE_MASK) | (live_i & LIVE_MASK);
    cause_o = merged & ~(mret_path_i ? CLR_MRET : CLR_NRET);
  end

  assign pie_o   = saved_i[27];
  assign pdt_o   = saved_i[29];
  assign plvl_o  = saved_i[19:16];
  assign ie_o    = saved_i[28];
  assign nplvl_o = saved_i[23:20];

endmodule

// File: rtl/irq_epilogue_seq.sv
module irq_epilogue_seq
  import irq_epi_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned FRAME_BYTES = 96,
  parameter int unsigned RA          = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic            nmi_en_i,
  input  logic [XLEN-1:0] cause_live_i,
  input  logic [XLEN-1:0] trap_epc_i,
  input  logic [XLEN-1:0] nmi_epc_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            rf_we_o,
  output logic [RA-1:0]   rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            cause_we_o,
  output logic [XLEN-1:0] cause_wdata_o,
  output logic            mret_we_o,
  output logic            mret_pie_o,
  output logic            mret_pdt_o,
  output logic [3:0]      mret_plvl_o,
  output logic            nret_we_o,
  output logic            nret_ie_o,
  output logic [3:0]      nret_plvl_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] saved_ret_o
);

  localparam int unsigned IW = $clog2(EPI_SLOTS);
  localparam logic [IW-1:0] LAST_SLOT = IW'(EPI_SLOTS - 1);
  localparam logic [IW-1:0] LAST_WB   = IW'(EPI_GPRS);
  localparam logic [RA-1:0] SP_REG    = RA'(2);

  logic            rst_n;
  epi_state_e      state_q, state_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [XLEN-1:0] top_q;
  logic            path_q;
  logic            ctx_en;

  logic            buf_we;
  logic [IW-1:0]   buf_rd_idx;
  logic [XLEN-1:0] buf_rd_data;
  logic [XLEN-1:0] ret_word;
  logic [XLEN-1:0] cause_word;
  logic            wb_is_sp;
  logic [XLEN-1:0] merged_cause;

  epi_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ctx_en  = 1'b0;
    unique case (state_q)
      EPI_IDLE: begin
        if (start_i) begin
          state_d = EPI_POP;
          idx_d   = '0;
          ctx_en  = 1'b1;
        end
      end
      EPI_POP: begin
        if (mem_rvalid_i) begin
          if (idx_q == LAST_SLOT) begin
            state_d = EPI_WB;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      EPI_WB: begin
        if (idx_q == LAST_WB) begin
          state_d = EPI_FIN;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      EPI_FIN: begin
        state_d = EPI_IDLE;
      end
      default: begin
        state_d = EPI_IDLE;
      end
    endcase
  end

  // Control registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EPI_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // Context captured at start
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      path_q <= 1'b0;
    end else if (ctx_en) begin
      top_q  <= sp_i + XLEN'(FRAME_BYTES);
      path_q <= nmi_en_i;
    end
  end

  // Read port
  assign mem_req_o  = (state_q == EPI_POP);
  assign mem_addr_o = top_q - XLEN'(slot_offset(5'(idx_q)));
  assign buf_we     = mem_req_o && mem_rvalid_i;

  epi_frame_buf #(
    .W         (XLEN),
    .N         (EPI_SLOTS),
    .IW        (IW),
    .RET_IDX   (SLOT_RET),
    .CAUSE_IDX (SLOT_CAUSE)
  ) u_buf (
    .clk_i        (clk_i),
    .wr_en_i      (buf_we),
    .wr_idx_i     (idx_q),
    .wr_data_i    (mem_rdata_i),
    .rd_idx_i     (buf_rd_idx),
    .rd_data_o    (buf_rd_data),
    .ret_word_o   (ret_word),
    .cause_word_o (cause_word)
  );

  // Register write-back
  assign wb_is_sp   = (idx_q == LAST_WB);
  assign buf_rd_idx = IW'(wb_slot(5'(idx_q)));
  assign rf_we_o    = (state_q == EPI_WB);
  assign rf_waddr_o = wb_is_sp ? SP_REG : RA'(slot_gpr(5'(buf_rd_idx)));
  assign rf_wdata_o = wb_is_sp ? top_q : buf_rd_data;

  // Final CSR and PC update
  epi_csr_merge #(
    .W (XLEN)
  ) u_merge (
    .saved_i     (cause_word),
    .live_i      (cause_live_i),
    .mret_path_i (path_q),
    .cause_o     (merged_cause),
    .pie_o       (mret_pie_o),
    .pdt_o       (mret_pdt_o),
    .plvl_o      (mret_plvl_o),
    .ie_o        (nret_ie_o),
    .nplvl_o     (nret_plvl_o)
  );

  assign done_o        = (state_q == EPI_FIN);
  assign busy_o        = (state_q != EPI_IDLE);
  assign cause_we_o    = done_o;
  assign cause_wdata_o = merged_cause;
  assign mret_we_o     = done_o && path_q;
  assign nret_we_o     = done_o && !path_q;
  assign pc_o          = path_q ? trap_epc_i : nmi_epc_i;
  assign saved_ret_o   = ret_word;

endmodule

// File: rtl/epi_checker.sv
module epi_checker #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            rf_we_o,
  input logic [RA-1:0]   rf_waddr_o,
  input logic            cause_we_o,
  input logic [XLEN-1:0] cause_wdata_o,
  input logic [XLEN-1:0] cause_live_i,
  input logic            mret_we_o,
  input logic            nret_we_o
);

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o && !cause_we_o));

  p_start_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_no_early_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!rf_we_o && !cause_we_o));

  p_sp_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(rf_we_o) && ($past(rf_waddr_o) == RA'(2))));

  p_live_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_we_o |-> (cause_wdata_o[25:24] == cause_live_i[25:24]));

  p_one_path_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({mret_we_o, nret_we_o}) == 1));

  p_path_in_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_we_o || nret_we_o) |-> done_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

endmodule

bind irq_epilogue_seq epi_checker #(.XLEN(XLEN), .RA(RA)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .rf_we_o       (rf_we_o),
  .rf_waddr_o    (rf_waddr_o),
  .cause_we_o    (cause_we_o),
  .cause_wdata_o (cause_wdata_o),
  .cause_live_i  (cause_live_i),
  .mret_we_o     (mret_we_o),
  .nret_we_o     (nret_we_o)
);

// File: tb/sim_irq_epilogue_seq.sv
`timescale 1ns/1ps
module sim_irq_epilogue_seq;

  typedef struct packed {
    logic [31:0] sp;
    logic        nmi;
    logic [31:0] saved;
    logic [31:0] live;
    logic [31:0] tepc;
    logic [31:0] nepc;
    logic [1:0]  lat;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h0000_1000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_4000, 32'h0000_8000, 2'd0},
    '{32'h2000_0F00, 1'b0, 32'hA5C3_9E71, 32'hFFFF_FFFF, 32'h1111_2220, 32'h3333_4440, 2'd2},
    '{32'h7FFF_FFA0, 1'b1, 32'h3C0F_5A18, 32'h0300_0000, 32'h5555_6660, 32'h7777_8880, 2'd1},
    '{32'hFFFF_FFC0, 1'b0, 32'h5A5A_A5A5, 32'h0100_0000, 32'h0BAD_0000, 32'h0CAF_0004, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] sp_i = '0;
  logic        nmi_en_i = 1'b0;
  logic [31:0] cause_live_i = '0;
  logic [31:0] trap_epc_i = '0;
  logic [31:0] nmi_epc_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  logic        mem_req_o, rf_we_o, cause_we_o, mret_we_o, nret_we_o;
  logic        mret_pie_o, mret_pdt_o, nret_ie_o, busy_o, done_o;
  logic [31:0] mem_addr_o, rf_wdata_o, cause_wdata_o, pc_o, saved_ret_o;
  logic [4:0]  rf_waddr_o;
  logic [3:0]  mret_plvl_o, nret_plvl_o;

  always #4 clk = ~clk;

  irq_epilogue_seq u0 (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .sp_i (sp_i),
    .nmi_en_i (nmi_en_i), .cause_live_i (cause_live_i),
    .trap_epc_i (trap_epc_i), .nmi_epc_i (nmi_epc_i),
    .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i), .mem_rdata_i (mem_rdata_i),
    .rf_we_o (rf_we_o), .rf_waddr_o (rf_waddr_o), .rf_wdata_o (rf_wdata_o),
    .cause_we_o (cause_we_o), .cause_wdata_o (cause_wdata_o),
    .mret_we_o (mret_we_o), .mret_pie_o (mret_pie_o),
    .mret_pdt_o (mret_pdt_o), .mret_plvl_o (mret_plvl_o),
    .nret_we_o (nret_we_o), .nret_ie_o (nret_ie_o), .nret_plvl_o (nret_plvl_o),
    .busy_o (busy_o), .done_o (done_o), .pc_o (pc_o), .saved_ret_o (saved_ret_o)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // bench memory model and monitor state
  logic [31:0] cur_top, cur_cause, live_tgt;
  int          lat = 0;
  int          wcnt = 0;
  logic [31:0] addr_log [32];
  int          nreads = 0;
  logic [31:0] gpr_val [32];
  logic [4:0]  wr_order [32];
  int          nwr = 0;
  bit          early_wr = 0;
  int          done_cnt = 0;
  int          cwe_cnt = 0;
  bit          prev_done = 0;
  bit          busy_after_done = 0;
  logic [31:0] got_cause, got_pc, got_ret;
  logic        got_mwe, got_nwe, got_pie, got_pdt, got_ie;
  logic [3:0]  got_plvl, got_nplvl;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a == cur_top - 32'd12) return cur_cause;
    return (a * 32'h9E37_79B1) ^ 32'h5A17_C3E9;
  endfunction

  function automatic int exp_off(input int r);
    case (r)
      8: return 8;
      1: return 16;
      5: return 24;
      6: return 28;
      7: return 32;
      31: return 80;
      default: begin
        if (r >= 10 && r <= 17) return 36 + 4 * (r - 10);
        if (r >= 28 && r <= 30) return 68 + 4 * (r - 28);
        return 0;
      end
    endcase
  endfunction

  function automatic logic [31:0] exp_cause(input logic [31:0] s, input logic [31:0] l,
                                            input logic nmi);
    logic [31:0] m;
    m = (s & ~32'h0300_0000) | (l & 32'h0300_0000);
    return nmi ? (m & ~32'h2C0F_F000) : (m & ~32'h54F0_F000);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    nreads = 0; nwr = 0; early_wr = 0; done_cnt = 0; cwe_cnt = 0;
    busy_after_done = 0;
    for (int i = 0; i < 32; i++) gpr_val[i] = 'x;
  endtask

  // Monitor and memory responder, both at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (prev_done && busy_o) busy_after_done = 1;
      prev_done = done_o;
      if (rf_we_o) begin
        if (nreads < 19) early_wr = 1;
        gpr_val[rf_waddr_o] = rf_wdata_o;
        if (nwr < 32) wr_order[nwr] = rf_waddr_o;
        nwr++;
        if (rf_waddr_o == 5'd2) cause_live_i = live_tgt;
      end
      if (cause_we_o) cwe_cnt++;
      if (done_o) begin
        done_cnt++;
        got_cause = cause_wdata_o; got_pc = pc_o; got_ret = saved_ret_o;
        got_mwe = mret_we_o; got_nwe = nret_we_o;
        got_pie = mret_pie_o; got_pdt = mret_pdt_o; got_plvl = mret_plvl_o;
        got_ie = nret_ie_o; got_nplvl = nret_plvl_o;
      end
      if (!mem_req_o) begin
        mem_rvalid_i = 0; wcnt = 0;
      end else begin
        if (mem_rvalid_i) wcnt = 0;
        if (wcnt >= lat) begin
          mem_rvalid_i = 1;
          mem_rdata_i  = mem_word(mem_addr_o);
          if (nreads < 32) addr_log[nreads] = mem_addr_o;
          nreads++;
        end else begin
          mem_rvalid_i = 0;
          wcnt++;
        end
      end
    end
  end

  task automatic run_vec(input vec_t v);
    int bad;
    logic [31:0] top;
    clear_logs();
    top = v.sp + 32'd96;
    cur_top = top; cur_cause = v.saved; live_tgt = v.live; lat = int'(v.lat);
    sp_i = v.sp; nmi_en_i = v.nmi; cause_live_i = ~v.live;
    trap_epc_i = v.tepc; nmi_epc_i = v.nepc;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0; nmi_en_i = ~v.nmi; sp_i = 32'hDEAD_0000;
    chk(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 32'd1);
    for (int c = 0; c < 200 && nreads < 3; c++) @(posedge clk);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int c = 0; c < 600 && done_cnt == 0; c++) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(done_cnt == 1, "R11", "done pulses", 32'(done_cnt), 32'd1);
    chk(!busy_after_done, "R11", "busy after done", 32'(busy_after_done), 32'd0);
    chk(got_ret == mem_word(top - 32'd4), "R11", "saved return word", got_ret,
        mem_word(top - 32'd4));
    // R3 read addresses and count, also proves R2 second start ignored
    chk(nreads == 19, "R3", "read count", 32'(nreads), 32'd19);
    bad = 0;
    for (int i = 0; i < 19; i++) begin
      if (addr_log[i] != top - 32'((i < 4) ? 4 * (i + 1) : 4 * (i + 2))) bad++;
    end
    chk(bad == 0, "R3", "read address mismatches", 32'(bad), 32'd0);
    // R4 register contents
    bad = 0;
    for (int r = 1; r < 32; r++) begin
      if (exp_off(r) != 0 && gpr_val[r] !== mem_word(top - 32'(exp_off(r)))) bad++;
    end
    chk(bad == 0, "R4", "register data mismatches", 32'(bad), 32'd0);
    chk(!early_wr && nwr == 18, "R5", "write count (no early write)", 32'(nwr), 32'd18);
    chk(wr_order[17] == 5'd2 && gpr_val[2] == top, "R6", "x2 last with frame top",
        gpr_val[2], top);
    chk(got_cause[25:24] == v.live[25:24], "R7", "live bits in cause",
        32'(got_cause[25:24]), 32'(v.live[25:24]));
    chk(got_mwe == v.nmi && got_nwe == !v.nmi, "R10", "path from start-time enable",
        32'({got_mwe, got_nwe}), 32'({v.nmi, !v.nmi}));
    if (v.nmi) begin
      chk(got_cause == exp_cause(v.saved, v.live, 1'b1), "R8", "cause value", got_cause,
          exp_cause(v.saved, v.live, 1'b1));
      chk({got_pie, got_pdt, got_plvl} == {v.saved[27], v.saved[29], v.saved[19:16]},
          "R8", "status fields", 32'({got_pie, got_pdt, got_plvl}),
          32'({v.saved[27], v.saved[29], v.saved[19:16]}));
      chk(got_pc == v.tepc, "R8", "new pc", got_pc, v.tepc);
    end else begin
      chk(got_cause == exp_cause(v.saved, v.live, 1'b0), "R9", "cause value", got_cause,
          exp_cause(v.saved, v.live, 1'b0));
      chk({got_ie, got_nplvl} == {v.saved[28], v.saved[23:20]}, "R9", "status fields",
          32'({got_ie, got_nplvl}), 32'({v.saved[28], v.saved[23:20]}));
      chk(got_pc == v.nepc, "R9", "new pc", got_pc, v.nepc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #1 rst_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy_o, done_o, mem_req_o, rf_we_o, cause_we_o, mret_we_o, nret_we_o} == 7'd0,
        "R1", "outputs in reset", 32'({busy_o, done_o, mem_req_o, rf_we_o}), 32'd0);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, mem_req_o, rf_we_o, cause_we_o} == 5'd0, "R1",
        "outputs after reset", 32'({busy_o, done_o, mem_req_o}), 32'd0);

    for (int i = 0; i < 4; i++) run_vec(VECS[i]);

    // R12: reset in the middle of the read phase
    clear_logs();
    cur_top = VECS[1].sp + 32'd96; cur_cause = VECS[1].saved; lat = 1;
    sp_i = VECS[1].sp; nmi_en_i = 1'b0;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int c = 0; c < 200 && nreads < 6; c++) @(posedge clk);
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R12", "idle after mid reset", 32'({busy_o, mem_req_o}),
        32'd0);
    chk(nwr == 0 && cwe_cnt == 0, "R12", "no writes before abort", 32'(nwr + cwe_cnt),
        32'd0);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk(!busy_o && nwr == 0, "R12", "stays idle after release", 32'(busy_o), 32'd0);

    run_vec(VECS[2]);
    summary();
  end

endmodule